// File: doc/BRIEF.md
# PMIC Serial Bridge Register Controller

This block is the host-side register front end of a link to a remote power-management slave. A host reaches it through a simple valid/ready register port. Host writes that land inside the slave address window go into a small write queue. The queue drains them one at a time to the slave as word-addressed 16-bit write requests. Software starts a remote read by writing a slave register offset into a read-command register. A read-data register then reports a busy flag and, once the read finishes, the returned 16-bit value next to an echo of the address. Software compares the echo with the address it asked for to check the data.

A parameter sets the slave address width, which can be 10, 12 or 15 word-address bits. That choice fixes the window base and span: 0x8000 with a 4 KB span, 0x8000 with a 16 KB span, or 0x20000 with a 128 KB span. It also fixes which command bits form the echo, and whether the top two word-address bits pick one of several slaves. A read command waits until every queued write has been handed to the slave, so a read always sees the effect of the writes issued before it. The slave side is a request port with a valid/ready handshake and a separate response strobe that carries read data.

Top module: `pmic_bridge_ctrl`

## Requirements
- R1: A host write whose address lies inside the slave window is forwarded to the slave as a write request. Its word address is the window byte offset divided by four, masked to the configured address width. Its data is the low 16 bits of the host data. Such writes leave in the order they were accepted.
- R2: With 12 or 15 address bits, `s_req_sel` carries the top two bits of the request word address (bits 11:10 or 14:13). With 10 address bits it is 0.
- R3: A host write to the read-command register at offset 0x28 starts a remote read without any other trigger. Bit 31 of the read-data register (offset 0x2c) reads 1 from the next host access until the slave response arrives.
- R4: After completion, read-data bits [15:0] hold the slave value and bits [30:16] hold the echoed address. The echo is command bits [16:2] with 12 or 15 address bits, and command bits [14:0] with 10 address bits.
- R5: The read request is not presented to the slave until every write queued before the command has been accepted by the slave.
- R6: The status register at offset 0x30 shows the queue empty on bit 10, the queue full (FIFO_DEPTH entries held) on bit 11, and a sticky overflow flag on bit 12. The other bits read 0.
- R7: A window write that arrives while the queue is full is dropped and never reaches the slave. It sets the overflow flag, which stays set until reset.
- R8: The read-data contents stay unchanged until the next read command is accepted. A read command written while a read is busy is ignored.
- R9: While `s_req_valid` is high and `s_req_ready` is low, the request and its type, address and data stay unchanged.
- R10: After reset the status register reads 0x400 and the read-data register reads 0. Unmapped addresses read 0. Every host access is accepted at once, and a read returns its data with `h_rvalid` one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Host access accepted (always high) |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 18 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| s_req_valid | output | 1 | Slave request valid |
| s_req_ready | input | 1 | Slave accepts request |
| s_req_write | output | 1 | 1 = write request, 0 = read request |
| s_req_addr | output | 15 | Slave word address |
| s_req_sel | output | 2 | Slave select from top word-address bits |
| s_req_wdata | output | 16 | Slave write data |
| s_rsp_valid | input | 1 | Read response strobe |
| s_rsp_data | input | 16 | Read response value |

## Verification
A wrong queue count shows up at once in the status bits, on the next host read. It also shows as a write request that appears or goes missing at the slave port within a few cycles. A read sequencer stuck in the wrong state leaves the busy bit high indefinitely, or lets a read request reach the slave ahead of queued writes. That second case is visible on the very cycle the request is presented, because the slave has accepted fewer writes than the host issued. Corrupted echo or value registers appear in the first read-data poll after completion, and again on every later poll, which should be identical.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

    localparam int HADDR_W = 18;
    localparam int HDATA_W = 32;
    localparam int SDATA_W = 16;
    localparam int SWORD_W = 15;

    localparam logic [HADDR_W-1:0] REG_RDCMD  = 18'h00028;
    localparam logic [HADDR_W-1:0] REG_RDDATA = 18'h0002c;
    localparam logic [HADDR_W-1:0] REG_FSTAT  = 18'h00030;

    localparam int BUSY_BIT  = 31;
    localparam int OVF_BIT   = 12;
    localparam int FULL_BIT  = 11;
    localparam int EMPTY_BIT = 10;

    typedef struct packed {
        logic [SWORD_W-1:0] waddr;
        logic [SDATA_W-1:0] data;
    } wr_entry_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_DRAIN,
        RS_ISSUE,
        RS_WAIT
    } rd_state_e;

    function automatic logic [18:0] win_base(input int bits);
        return (bits == 15) ? 19'h20000 : 19'h08000;
    endfunction

    function automatic logic [18:0] win_span(input int bits);
        if (bits == 10) return 19'h01000;
        if (bits == 12) return 19'h04000;
        return 19'h20000;
    endfunction

    // Byte offset to word address, masked to the configured width.
    function automatic logic [SWORD_W-1:0] word_of(input logic [16:0] off, input int bits);
        logic [SWORD_W-1:0] m;
        for (int i = 0; i < SWORD_W; i++) m[i] = (i < bits);
        return off[16:2] & m;
    endfunction

    function automatic logic [1:0] sel_of(input logic [SWORD_W-1:0] w, input int bits);
        if (bits == 15) return w[14:13];
        if (bits == 12) return w[11:10];
        return 2'b00;
    endfunction

    function automatic logic [SWORD_W-1:0] echo_of(input logic [16:0] cmd, input int bits);
        return (bits == 10) ? cmd[14:0] : cmd[16:2];
    endfunction

endpackage

// File: rtl/pmic_wr_fifo.sv
module pmic_wr_fifo
    import pmic_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wr_entry_t push_data,
    input  logic      pop,
    output wr_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wr_entry_t          store [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pmic_rd_seq.sv
module pmic_rd_seq
    import pmic_bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_go,
    input  logic      fifo_empty,
    input  logic      req_ready,
    input  logic      rsp_valid,
    output logic      busy,
    output logic      rd_req,
    output logic      owns_port,
    output logic      done
);
    rd_state_e state;

    assign busy      = (state != RS_IDLE);
    assign rd_req    = (state == RS_ISSUE);
    assign owns_port = (state == RS_ISSUE) || (state == RS_WAIT);
    assign done      = (state == RS_WAIT) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
        end else begin
            case (state)
                RS_IDLE:  if (cmd_go)     state <= RS_DRAIN;
                RS_DRAIN: if (fifo_empty) state <= RS_ISSUE;
                RS_ISSUE: if (req_ready)  state <= RS_WAIT;
                RS_WAIT:  if (rsp_valid)  state <= RS_IDLE;
                default:                  state <= RS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pmic_bridge_ctrl.sv
module pmic_bridge_ctrl
    import pmic_bridge_pkg::*;
#(
    parameter int ADDR_BITS  = 12,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        h_valid,
    output logic        h_ready,
    input  logic        h_write,
    input  logic [17:0] h_addr,
    input  logic [31:0] h_wdata,
    output logic        h_rvalid,
    output logic [31:0] h_rdata,
    output logic        s_req_valid,
    input  logic        s_req_ready,
    output logic        s_req_write,
    output logic [14:0] s_req_addr,
    output logic [1:0]  s_req_sel,
    output logic [15:0] s_req_wdata,
    input  logic        s_rsp_valid,
    input  logic [15:0] s_rsp_data
);
    localparam logic [18:0] WIN_BASE = win_base(ADDR_BITS);
    localparam logic [18:0] WIN_END  = win_base(ADDR_BITS) + win_span(ADDR_BITS);

    logic               wr_acc, rd_acc, in_win, cmd_go, pop, push;
    logic [HADDR_W-1:0] win_off;
    logic               fifo_empty, fifo_full;
    wr_entry_t          head, entry_in;
    logic               busy, rd_req, owns_port, done;
    logic [SWORD_W-1:0] cmd_word, echo_q;
    logic [SDATA_W-1:0] value_q;
    logic               ovf_q;
    logic [HDATA_W-1:0] rd_mux;
    logic               unused_bits;

    assign h_ready     = 1'b1;
    assign wr_acc      = h_valid && h_write;
    assign rd_acc      = h_valid && !h_write;
    assign in_win      = ({1'b0, h_addr} >= WIN_BASE) && ({1'b0, h_addr} < WIN_END);
    assign win_off     = h_addr - WIN_BASE[HADDR_W-1:0];
    assign push        = wr_acc && in_win && !fifo_full;
    assign cmd_go      = wr_acc && (h_addr == REG_RDCMD) && !busy;
    assign unused_bits = ^{h_wdata[31:17], win_off[17]};

    assign entry_in.waddr = word_of(win_off[16:0], ADDR_BITS);
    assign entry_in.data  = h_wdata[15:0];

    pmic_wr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_data(entry_in), .pop(pop),
        .head(head), .empty(fifo_empty), .full(fifo_full)
    );

    pmic_rd_seq u_seq (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .fifo_empty(fifo_empty),
        .req_ready(s_req_ready), .rsp_valid(s_rsp_valid),
        .busy(busy), .rd_req(rd_req), .owns_port(owns_port), .done(done)
    );

    // Slave port: reads own it from issue to response, otherwise queue head.
    assign s_req_valid = rd_req || (!owns_port && !fifo_empty);
    assign s_req_write = !owns_port;
    assign s_req_addr  = owns_port ? cmd_word : head.waddr;
    assign s_req_wdata = owns_port ? '0 : head.data;
    assign s_req_sel   = sel_of(s_req_addr, ADDR_BITS);
    assign pop         = s_req_valid && s_req_ready && s_req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word <= '0;
            echo_q   <= '0;
            value_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (cmd_go) begin
                cmd_word <= word_of(h_wdata[16:0], ADDR_BITS);
                echo_q   <= echo_of(h_wdata[16:0], ADDR_BITS);
            end
            if (done) value_q <= s_rsp_data;
            if (wr_acc && in_win && fifo_full) ovf_q <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (h_addr)
            REG_RDDATA: rd_mux = {busy, echo_q, value_q};
            REG_FSTAT: begin
                rd_mux[OVF_BIT]   = ovf_q;
                rd_mux[FULL_BIT]  = fifo_full;
                rd_mux[EMPTY_BIT] = fifo_empty;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
        end else begin
            h_rvalid <= rd_acc;
            if (rd_acc) h_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_req_valid,
    input logic        s_req_ready,
    input logic        s_req_write,
    input logic [14:0] s_req_addr,
    input logic [15:0] s_req_wdata,
    input logic        cmd_go,
    input logic        busy,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic        ovf_q,
    input logic [15:0] value_q,
    input logic [14:0] echo_q
);
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (s_req_valid && !s_req_ready) |=> (s_req_valid && $stable(s_req_write)
            && $stable(s_req_addr) && $stable(s_req_wdata)));

    a_r5_read_after_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(s_req_valid && !s_req_write) |-> $past(fifo_empty));

    a_r3_busy_set: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> busy);

    a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !(s_req_valid && s_req_ready && s_req_write)) |=> fifo_full);

    a_r8_result_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_go) |=> ($stable(value_q) && $stable(echo_q)));
endmodule

bind pmic_bridge_ctrl pmic_bridge_chk u_chk (
    .clk(clk), .rst(rst), .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
    .s_req_write(s_req_write), .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
    .cmd_go(cmd_go), .busy(busy), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ovf_q(ovf_q), .value_q(value_q), .echo_q(echo_q)
);

// File: tb/sim_pmic_bridge_ctrl.sv
`timescale 1ns/1ps
module sim_pmic_bridge_ctrl;
    localparam int DEPTH = 4;
    localparam logic [17:0] BASE = 18'h08000;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_CMD = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [17:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{K_RD,  18'h00030, 32'h0,      32'h00000400},
        '{K_WR,  18'h00010, 32'hBEEF,   32'h0},
        '{K_WR,  18'h03004, 32'h1234,   32'h0},
        '{K_CMD, 18'h00010, 32'h0,      32'h0},
        '{K_CMD, 18'h03004, 32'h0,      32'h0},
        '{K_CMD, 18'h00020, 32'h0,      32'h0},
        '{K_RD,  18'h00030, 32'h0,      32'h00000400},
        '{K_RD,  18'h00000, 32'h0,      32'h0},
        '{K_WR,  18'h01FFC, 32'h7E7E,   32'h0},
        '{K_CMD, 18'h01FFC, 32'h0,      32'h0}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        h_valid = 1'b0, h_write = 1'b0;
    logic [17:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready, h_rvalid;
    logic [31:0] h_rdata;
    logic        s_req_valid, s_req_write, s_rsp_valid;
    logic [14:0] s_req_addr;
    logic [1:0]  s_req_sel;
    logic [15:0] s_req_wdata, s_rsp_data;
    logic        stall = 1'b0;
    logic        s_req_ready;

    int checks = 0, fails = 0;
    int wr_count = 0, rd_seen_wr = 0, rsp_cnt = 0;
    logic [14:0] last_addr, rsp_addr;
    logic [15:0] last_data;
    logic [1:0]  last_sel;
    logic [15:0] smem [256];
    logic [15:0] rmem [256];
    logic        last_rvalid;

    always #2.5 clk = ~clk;
    assign s_req_ready = !stall;

    pmic_bridge_ctrl #(.ADDR_BITS(12), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
        .s_req_addr(s_req_addr), .s_req_sel(s_req_sel), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_data(s_rsp_data)
    );

    // Slave model
    assign s_rsp_valid = (rsp_cnt == 1);
    assign s_rsp_data  = smem[rsp_addr[7:0]];
    always @(posedge clk) begin
        if (rsp_cnt != 0) rsp_cnt <= rsp_cnt - 1;
        if (!rst && s_req_valid && s_req_ready) begin
            if (s_req_write) begin
                smem[s_req_addr[7:0]] <= s_req_wdata;
                wr_count  <= wr_count + 1;
                last_addr <= s_req_addr;
                last_data <= s_req_wdata;
                last_sel  <= s_req_sel;
            end else begin
                rd_seen_wr <= wr_count;
                rsp_addr   <= s_req_addr;
                rsp_cnt    <= 3;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        h_valid = 1'b1; h_write = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_valid = 1'b0; h_write = 1'b0;
    endtask

    task automatic host_rd(input logic [17:0] a, output logic [31:0] d);
        @(negedge clk);
        h_valid = 1'b1; h_write = 1'b0; h_addr = a;
        @(negedge clk);
        h_valid = 1'b0;
        d = h_rdata;
        last_rvalid = h_rvalid;
    endtask

    task automatic poll(output logic [31:0] d);
        for (int k = 0; k < 200; k++) begin
            host_rd(18'h0002c, d);
            if (!d[31]) break;
        end
    endtask

    task automatic wait_wr(input int prev);
        for (int k = 0; k < 50; k++) begin
            if (wr_count > prev) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [17:0] off);
        logic [14:0] w;
        w = {3'b000, off[13:2]};
        return {1'b0, off[16:2], rmem[w[7:0]]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0;
        logic [14:0] wa;
        for (int i = 0; i < 256; i++) begin
            smem[i] = 16'h1000 + 16'(i);
            rmem[i] = 16'h1000 + 16'(i);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        host_rd(18'h00030, d);
        chk(d == 32'h400, "R10 status after reset", d, 32'h400);
        chk(last_rvalid == 1'b1, "R10 rvalid one cycle after accept", {31'h0, last_rvalid}, 32'h1);
        host_rd(18'h0002c, d);
        chk(d == 32'h0, "R10 read data after reset", d, 32'h0);

        // Vector table
        for (int v = 0; v < 10; v++) begin
            case (VECS[v].kind)
                K_WR: begin
                    w0 = wr_count;
                    wa = {3'b000, VECS[v].addr[13:2]};
                    host_wr(BASE + VECS[v].addr, VECS[v].data);
                    rmem[wa[7:0]] = VECS[v].data[15:0];
                    wait_wr(w0);
                    chk(last_addr == wa && last_data == VECS[v].data[15:0], "R1 forwarded write",
                        {1'b0, last_addr, last_data}, {1'b0, wa, VECS[v].data[15:0]});
                    chk(last_sel == wa[11:10], "R2 slave select", {30'h0, last_sel}, {30'h0, wa[11:10]});
                end
                K_RD: begin
                    host_rd(VECS[v].addr, d);
                    chk(d == VECS[v].exp, "R6/R10 register read", d, VECS[v].exp);
                end
                default: begin
                    host_wr(18'h00028, {14'h0, VECS[v].addr});
                    poll(d);
                    chk(d == exp_rd(VECS[v].addr), "R4 read result", d, exp_rd(VECS[v].addr));
                end
            endcase
        end

        // R3 R5 R9: read behind queued writes with the slave stalled
        w0 = wr_count;
        stall = 1'b1;
        host_wr(BASE + 18'h040, 32'hA1A1); rmem[8'h10] = 16'hA1A1;
        host_wr(BASE + 18'h044, 32'hB2B2); rmem[8'h11] = 16'hB2B2;
        host_wr(18'h00028, 32'h40);
        host_rd(18'h0002c, d);
        chk(d[31] == 1'b1, "R3 busy after command", d, 32'h80000000);
        chk(s_req_valid && s_req_write && s_req_addr == 15'h10, "R9 head held while stalled",
            {16'h0, s_req_valid, s_req_addr}, {16'h0, 1'b1, 15'h10});
        stall = 1'b0;
        poll(d);
        chk(rd_seen_wr == w0 + 2, "R5 writes drained before read", rd_seen_wr, w0 + 2);
        chk(d == 32'h0010A1A1, "R4 value after drain", d, 32'h0010A1A1);

        // R8: command during busy ignored, result held
        stall = 1'b1;
        host_wr(18'h00028, 32'h44);
        host_wr(18'h00028, 32'h40);
        stall = 1'b0;
        poll(d);
        chk(d == 32'h0011B2B2, "R8 second command ignored", d, 32'h0011B2B2);
        w0 = wr_count;
        host_wr(BASE + 18'h044, 32'hCCCC); rmem[8'h11] = 16'hCCCC;
        wait_wr(w0);
        host_rd(18'h0002c, d);
        chk(d == 32'h0011B2B2, "R8 result stable", d, 32'h0011B2B2);

        // R4: echo uses command bits 16:2
        host_wr(18'h00028, 32'h10010);
        poll(d);
        chk(d == 32'h4004BEEF, "R4 echo upper bits", d, 32'h4004BEEF);

        // R6 R7: full queue and overflow
        w0 = wr_count;
        stall = 1'b1;
        for (int i = 0; i < DEPTH; i++) host_wr(BASE + 18'h080 + 18'(4 * i), 32'h100 + 32'(i));
        host_rd(18'h00030, d);
        chk(d == 32'h800, "R6 full flag", d, 32'h800);
        host_wr(BASE + 18'h090, 32'hDEAD);
        host_rd(18'h00030, d);
        chk(d == 32'h1800, "R7 overflow flagged", d, 32'h1800);
        stall = 1'b0;
        repeat (30) @(negedge clk);
        host_rd(18'h00030, d);
        chk(d == 32'h1400, "R6 empty with sticky overflow", d, 32'h1400);
        chk(wr_count == w0 + DEPTH, "R7 dropped write not forwarded", wr_count, w0 + DEPTH);
        host_wr(18'h00028, 32'h090);
        poll(d);
        chk(d == 32'h00241024, "R7 dropped value absent", d, 32'h00241024);
        host_wr(18'h00028, 32'h080);
        poll(d);
        chk(d == 32'h00200100, "R1 queued write order kept", d, 32'h00200100);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule